// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block generates the access address for one port of a synchronous memory. On every clock it chooses the internal address from one of three sources: the external address bus, a counter that steps up by one, or a copy of the base address captured by the most recent external load. Three active-low controls make the choice: an address strobe, a counter enable and a repeat control. A second output reports which operation the block performed in that cycle.

The block keeps a base register that is separate from the counter. The base register holds the last address taken from the bus. When repeat is asserted, that base goes back into the counter in the same cycle as the access, so the port never loses a cycle. After any operation the counter holds the address that was just accessed. Hold and advance therefore carry on from there.

A parameter adds one register stage on the address and operation outputs. This matches pipelined read timing, where data arrives one cycle later than in flow-through mode. All controls are plain level signals sampled on every clock. The block has no handshake and does no back-pressure: every cycle performs exactly one operation.

Top module: `burst_addr_gen`

## Requirements
- R1: When `ads_n` is low, the flow-through address equals `ext_addr_i` in the same cycle, whatever `rpt_n` and `cnten_n` are. `op_o` reads 2'b01 (load). That address becomes both the new counter value and the new base.
- R2: When `ads_n`, `rpt_n` and `cnten_n` are all high, the address equals the one accessed in the previous cycle. `op_o` reads 2'b00 (hold).
- R3: When `ads_n` is high, `rpt_n` is high and `cnten_n` is low, the address is the previous cycle's address plus one. This advanced address is accessed in that same cycle. `op_o` reads 2'b10 (advance).
- R4: An advance from the all-ones address produces address zero.
- R5: When `ads_n` is high and `rpt_n` is low, the address equals the base captured by the most recent load, with no idle cycle. `op_o` reads 2'b11 (repeat). Later advances count up from that base.
- R6: Priority is load, then repeat, then advance, then hold. A low `ads_n` overrides both other controls, and a low `rpt_n` overrides `cnten_n`.
- R7: A synchronous reset (`rst` high) clears both the counter and the base to zero. After reset, hold and repeat both give address zero.
- R8: With `PIPELINED`=1, `addr_o` and `op_o` show the flow-through values one clock later. While in reset they read zero and 2'b00.
- R9: Only a load changes the base. Advances, holds and repeats leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low: take the external address |
| cnten_n | input | 1 | Counter enable, active low: step the counter by one |
| rpt_n | input | 1 | Repeat, active low: reload the last loaded base |
| ext_addr_i | input | ADDR_W | External address bus |
| addr_o | output | ADDR_W | Internal access address |
| op_o | output | 2 | Operation performed: 00 hold, 01 load, 10 advance, 11 repeat |

## Verification
The bench builds two copies of the block side by side, both with `ADDR_W`=4. One copy uses `PIPELINED`=0 and the other uses `PIPELINED`=1, and both receive the same stimulus. The 4-bit width lets a short run of advances reach the wrap from 15 to 0. The paired copies show the one-cycle delay of the pipelined copy directly against the flow-through copy and against the model. Directed sequences cover each operation and each priority conflict. They are followed by a long random stream in which the strobe, repeat and enable controls often overlap.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_LOAD = 2'b01,
    OP_ADV  = 2'b10,
    OP_RPT  = 2'b11
  } bac_op_e;

endpackage

// File: rtl/bac_select.sv
// Chooses the address for this cycle: load, then repeat, then advance, then hold.
module bac_select
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              ads_n,
  input  logic              cnten_n,
  input  logic              rpt_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] cnt_q,
  input  logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] sel_addr,
  output bac_op_e           sel_op
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] cnt_inc;

  // Advance wraps naturally at the width of the counter.
  assign cnt_inc = cnt_q + STEP;

  always_comb begin
    if (!ads_n) begin
      sel_addr = ext_addr;
      sel_op   = OP_LOAD;
    end else if (!rpt_n) begin
      sel_addr = base_q;
      sel_op   = OP_RPT;
    end else if (!cnten_n) begin
      sel_addr = cnt_inc;
      sel_op   = OP_ADV;
    end else begin
      sel_addr = cnt_q;
      sel_op   = OP_HOLD;
    end
  end

endmodule

// File: rtl/bac_regs.sv
// Counter and base registers. The counter always takes the address accessed this cycle.
module bac_regs
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  bac_op_e           sel_op,
  input  logic [ADDR_W-1:0] sel_addr,
  output logic [ADDR_W-1:0] cnt_q,
  output logic [ADDR_W-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      cnt_q <= sel_addr;
      if (sel_op == OP_LOAD) begin
        base_q <= sel_addr;
      end
    end
  end

endmodule

// File: rtl/bac_out_stage.sv
// Optional output register that gives pipelined read timing.
module bac_out_stage
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter bit PIPELINED = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sel_addr,
  input  bac_op_e           sel_op,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        op_o
);

  generate
    if (PIPELINED) begin : g_pipe
      logic [ADDR_W-1:0] addr_q;
      bac_op_e           op_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          addr_q <= '0;
          op_q   <= OP_HOLD;
        end else begin
          addr_q <= sel_addr;
          op_q   <= sel_op;
        end
      end
      assign addr_o = addr_q;
      assign op_o   = op_q;
    end else begin : g_flow
      assign addr_o = sel_addr;
      assign op_o   = sel_op;
    end
  endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter bit PIPELINED = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_n,
  input  logic              cnten_n,
  input  logic              rpt_n,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        op_o
);

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] sel_addr;
  bac_op_e           sel_op;

  bac_select #(.ADDR_W(ADDR_W)) u_select (
    .ads_n    (ads_n),
    .cnten_n  (cnten_n),
    .rpt_n    (rpt_n),
    .ext_addr (ext_addr_i),
    .cnt_q    (cnt_q),
    .base_q   (base_q),
    .sel_addr (sel_addr),
    .sel_op   (sel_op)
  );

  bac_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sel_op   (sel_op),
    .sel_addr (sel_addr),
    .cnt_q    (cnt_q),
    .base_q   (base_q)
  );

  bac_out_stage #(.ADDR_W(ADDR_W), .PIPELINED(PIPELINED)) u_out (
    .clk      (clk),
    .rst      (rst),
    .sel_addr (sel_addr),
    .sel_op   (sel_op),
    .addr_o   (addr_o),
    .op_o     (op_o)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W    = 16,
  parameter bit PIPELINED = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              ads_n,
  input logic              cnten_n,
  input logic              rpt_n,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        op_o,
  input logic [ADDR_W-1:0] sel_addr,
  input logic [1:0]        sel_op
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              armed;
  logic [ADDR_W-1:0] last_load;

  // armed is set once the cycle after reset has passed, so $past never looks into reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      last_load <= '0;
    end else begin
      armed <= 1'b1;
      if (!ads_n) last_load <= ext_addr_i;
    end
  end

  // R1
  load_takes_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !ads_n |-> (sel_addr == ext_addr_i && sel_op == 2'b01));

  // R2
  hold_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (ads_n && rpt_n && cnten_n) |-> (sel_addr == $past(sel_addr) && sel_op == 2'b00));

  // R3
  advance_steps_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (ads_n && rpt_n && !cnten_n) |-> (sel_addr == $past(sel_addr) + ONE && sel_op == 2'b10));

  // R5
  repeat_restores_chk: assert property (@(posedge clk) disable iff (rst)
    (ads_n && !rpt_n) |-> (sel_addr == last_load && sel_op == 2'b11));

  generate
    if (PIPELINED) begin : g_pipe_chk
      // R8
      pipe_delay_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (addr_o == $past(sel_addr) && op_o == $past(sel_op)));
    end
  endgenerate

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .PIPELINED(PIPELINED)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ads_n      (ads_n),
  .cnten_n    (cnten_n),
  .rpt_n      (rpt_n),
  .ext_addr_i (ext_addr_i),
  .addr_o     (addr_o),
  .op_o       (op_o),
  .sel_addr   (sel_addr),
  .sel_op     (sel_op)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

  localparam int PERIOD = 10;
  localparam int W      = 4;
  localparam int MODV   = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ads_n = 1'b1, cnten_n = 1'b1, rpt_n = 1'b1;
  logic [W-1:0] ext_addr = '0;
  logic [W-1:0] addr_f, addr_p;
  logic [1:0]   op_f, op_p;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference model state
  int cnt = 0, base = 0, padr = 0, pop = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(W), .PIPELINED(1'b0)) u_burst_addr_gen (
    .clk(clk), .rst(rst), .ads_n(ads_n), .cnten_n(cnten_n), .rpt_n(rpt_n),
    .ext_addr_i(ext_addr), .addr_o(addr_f), .op_o(op_f)
  );

  burst_addr_gen #(.ADDR_W(W), .PIPELINED(1'b1)) u_burst_addr_gen_pipe (
    .clk(clk), .rst(rst), .ads_n(ads_n), .cnten_n(cnten_n), .rpt_n(rpt_n),
    .ext_addr_i(ext_addr), .addr_o(addr_p), .op_o(op_p)
  );

  task automatic check(input string tag, input int act_a, input int act_o,
                       input int exp_a, input int exp_o);
    checks++;
    if (act_a != exp_a || act_o != exp_o) begin
      errors++;
      $display("FAIL %s: addr=%0d op=%0d expected addr=%0d op=%0d",
               tag, act_a, act_o, exp_a, exp_o);
    end
  endtask

  task automatic step(input bit a, input bit c, input bit r, input int ext, input string tag);
    int eadr, eop;
    @(negedge clk);
    ads_n = a; cnten_n = c; rpt_n = r; ext_addr = W'(ext);
    if (!a)      begin eadr = ext % MODV;        eop = 1; end
    else if (!r) begin eadr = base;              eop = 3; end
    else if (!c) begin eadr = (cnt + 1) % MODV;  eop = 2; end
    else         begin eadr = cnt;               eop = 0; end
    #(PERIOD/4);
    check(tag, int'(addr_f), int'(op_f), eadr, eop);
    check("R8", int'(addr_p), int'(op_p), padr, pop);
    @(posedge clk);
    cnt = eadr;
    if (!a) base = eadr;
    padr = eadr; pop = eop;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R7 / R8: the pipelined outputs read zero and hold while in reset
    #(PERIOD/4);
    check("R7", int'(addr_p), int'(op_p), 0, 0);
    @(negedge clk); rst = 1'b0;
    step(1, 1, 1, 0, "R7");   // hold after reset -> 0
    step(1, 1, 0, 7, "R7");   // repeat after reset -> base 0
    step(0, 1, 1, 5, "R1");   // load 5
    step(1, 0, 1, 0, "R3");   // 6
    step(1, 0, 1, 0, "R3");   // 7
    step(1, 0, 1, 0, "R3");   // 8
    step(1, 1, 1, 2, "R2");   // hold 8
    step(1, 1, 1, 3, "R2");   // hold 8
    step(1, 1, 0, 0, "R9");   // repeat -> 5, base untouched by advances
    step(1, 0, 1, 0, "R5");   // advance from restored base -> 6
    step(0, 0, 0, 9, "R6");   // load wins over repeat and enable
    step(1, 0, 0, 0, "R6");   // repeat wins over enable -> 9
    step(0, 1, 1, 14, "R1");  // load 14
    step(1, 0, 1, 0, "R3");   // 15
    step(1, 0, 1, 0, "R4");   // wrap to 0
    step(1, 1, 0, 0, "R5");   // repeat -> 14
    for (int i = 0; i < 400; i++) begin
      bit a, c, r;
      string tg;
      a = ($urandom % 4) == 0;
      c = ($urandom % 3) == 0;
      r = ($urandom % 5) == 0;
      a = !a; c = !c; r = !r;
      if (!a) tg = "R1";
      else if (!r) tg = "R5";
      else if (!c) tg = (cnt == MODV - 1) ? "R4" : "R3";
      else tg = "R2";
      step(a, c, r, int'($urandom % MODV), tg);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule